// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar in packed BCD registers. A one-cycle `tick` enable, asserted once per second by the surrounding logic, advances the count. Seconds carry into minutes, minutes into hours, and hours into the day of the month and the weekday together. The date rolls into the month and the month rolls into a two-digit year. The day-of-month limit follows the length of each month, and February has 29 days in leap years.

Software reaches every field through a simple synchronous write port and a combinational read port, using eight byte addresses. A control register selects either a 24-hour hour format or a 12-hour format with an AM/PM bit, can halt timekeeping, and can return the block to its default state. The top bit of the seconds register is a clock-integrity flag. An oscillator-failure input sets it, and software clears it by writing the seconds register.

Top module: `bcd_rtc_cal`

## Requirements
- R1: After `rst_n` is low, the registers read: control 0x00, seconds 0x80 (integrity flag set), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00.
- R2: Address map: 0 control, 1 seconds, 2 minutes, 3 hours, 4 date, 5 weekday, 6 month, 7 year. A write takes effect at the next clock edge. Stored widths are: seconds 8 bits, minutes 7 bits, hours 6 bits, date 6 bits, weekday 3 bits, month 5 bits, year 8 bits. Unstored bits read as 0. Control reads back bit 3 (12-hour select) and bit 5 (halt).
- R3: Each accepted tick increments seconds in BCD from 00 to 59. The wrap from 59 to 00 increments minutes in BCD, and the minutes wrap from 59 to 00 carries into the hours.
- R4: With control bit 3 at 0, hours count 00 to 23 in BCD. The step from 23 to 00 advances the date and the weekday by one.
- R5: With control bit 3 at 1, the hour register holds 1 to 12 in BCD in bits 4:0, and bit 5 set means PM. The sequence runs 11 to 12 with the PM bit toggled, 12 to 1 with the PM bit kept, and otherwise adds one. Only the step from 11 PM (0x31) to 12 AM (0x12) advances the date.
- R6: The date wraps to 01 after its last value: 30 in months 04, 06, 09 and 11; 31 in the other months except February; and in February 29 when the BCD year's value is divisible by 4, otherwise 28.
- R7: A date wrap advances the month. The month wraps from 12 to 01 and then advances the year, and the year wraps from 99 to 00.
- R8: The weekday counts 0 to 6 and wraps from 6 to 0.
- R9: While control bit 5 is set, ticks are ignored and no time field changes.
- R10: A high `osc_fail` sets seconds bit 7 at the next edge. Ticks keep the flag unchanged. A seconds write stores bit 7 from the written data, so writing 0 clears the flag.
- R11: On an edge where `wr_en` is high, a tick has no effect. Only the addressed register changes, and no carry occurs.
- R12: Writing control with bit 4 set returns every register to its R1 value, and bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Once-per-second advance enable |
| osc_fail | input | 1 | Oscillator interruption event, sets the integrity flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
Three sweeps exercise the carry chain. The first is a full hour of consecutive ticks, which separates plain BCD digit stepping from the 59-to-00 carries. The second sets every hour value just before a carry, in both hour formats, which shows where the 12-hour sequence differs from the 24-hour one and which hour alone moves the date. The third steps across the last day of every month of every year 00 to 99, and across the day before it. It separates the three month lengths, the leap rule and the month and year wraps from an ordinary date step. Directed cases cover a tick arriving together with a write, a tick arriving while halted, the integrity flag, the soft reset and the write masks.

// File: rtl/bcd_rtc_cal.sv
module bcd_rtc_cal #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              osc_fail,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(7);

  logic       h12, halt;
  logic [7:0] sec_q, min_q, hr_q, date_q, wday_q, mon_q, yr_q;
  logic [7:0] hr_next, last_day;
  logic       leap;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  wire adv       = tick & ~halt & ~wr_en;
  wire sec_wrap  = (sec_q[6:0] == 7'h59);
  wire min_wrap  = (min_q == 8'h59);
  wire hr_wrap   = h12 ? (hr_q == 8'h31) : (hr_q == 8'h23);
  wire date_wrap = (date_q == last_day);
  wire mon_wrap  = (mon_q == 8'h12);
  wire c_min     = adv & sec_wrap;
  wire c_hr      = c_min & min_wrap;
  wire c_day     = c_hr & hr_wrap;
  wire c_mon     = c_day & date_wrap;
  wire c_yr      = c_mon & mon_wrap;

  assign leap = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                        : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);

  always_comb begin
    case (mon_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    if (h12) begin
      if (hr_q[4:0] == 5'h12)      hr_next = {2'b00, hr_q[5], 5'h01};
      else if (hr_q[4:0] == 5'h11) hr_next = {2'b00, ~hr_q[5], 5'h12};
      else                         hr_next = bcd_inc({3'b000, hr_q[4:0]}) | {2'b00, hr_q[5], 5'b0};
    end else begin
      hr_next = (hr_q == 8'h23) ? 8'h00 : bcd_inc(hr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (wr_en && addr == A_CTRL && wdata[4])) begin
      h12    <= 1'b0;
      halt   <= 1'b0;
      sec_q  <= 8'h80;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      date_q <= 8'h01;
      wday_q <= 8'h00;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTRL: begin h12 <= wdata[3]; halt <= wdata[5]; end
          A_SEC:  sec_q  <= wdata;
          A_MIN:  min_q  <= wdata & 8'h7F;
          A_HR:   hr_q   <= wdata & 8'h3F;
          A_DATE: date_q <= wdata & 8'h3F;
          A_WDAY: wday_q <= wdata & 8'h07;
          A_MON:  mon_q  <= wdata & 8'h1F;
          A_YR:   yr_q   <= wdata;
          default: ;
        endcase
      end else if (adv) begin
        sec_q <= sec_wrap ? (sec_q & 8'h80) : (bcd_inc(sec_q & 8'h7F) | (sec_q & 8'h80));
        if (c_min) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
        if (c_hr)  hr_q  <= hr_next;
        if (c_day) begin
          date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
          wday_q <= (wday_q >= 8'd6) ? 8'h00 : wday_q + 8'd1;
        end
        if (c_mon) mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
        if (c_yr)  yr_q  <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
      end
      if (osc_fail) sec_q[7] <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {2'b00, halt, 1'b0, h12, 3'b000};
      A_SEC:   rdata = sec_q;
      A_MIN:   rdata = min_q;
      A_HR:    rdata = hr_q;
      A_DATE:  rdata = date_q;
      A_WDAY:  rdata = wday_q;
      A_MON:   rdata = mon_q;
      A_YR:    rdata = yr_q;
      default: rdata = 8'h00;
    endcase
  end

  // R10
  osc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> sec_q[7]);

  // R10
  osc_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEC && !wdata[7] && !osc_fail) |=> !sec_q[7]);

  // R2
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEC) |=> sec_q[6:0] == $past(wdata[6:0]));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(sec_q[6:0]) && $stable(min_q) && $stable(hr_q) &&
                          $stable(date_q) && $stable(mon_q) && $stable(yr_q)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(sec_q[6:0]) && $stable(min_q) && $stable(hr_q) &&
                           $stable(wday_q) && $stable(mon_q)));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !wr_en && sec_q[6:0] == 7'h59) |=>
      (sec_q[6:0] == 7'h00 && min_q != $past(min_q)));

endmodule

// File: tb/bcd_rtc_cal_tb.sv
module bcd_rtc_cal_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       osc_fail = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_errors = 0;

  bcd_rtc_cal #(.ADDR_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_fail(osc_fail),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_tk(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; tick = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 3'(a);
    #1;
    d = rdata;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] w, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(1, s); wr(2, m); wr(3, h); wr(4, d); wr(5, w); wr(6, mo); wr(7, y);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c;
    logic [7:0] rst_exp [8];
    rst_exp = '{8'h00, 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 8; i++) begin
      rd(i, a);
      chk($sformatf("R1 reset addr %0d", i), {24'd0, a}, {24'd0, rst_exp[i]});
    end

    // R10 flag kept by tick, cleared by write, set by osc_fail
    tk(); rd(1, a); chk("R10 flag kept on tick", {24'd0, a}, 32'h81);
    wr(1, 8'h07); rd(1, a); chk("R10 flag cleared by write", {24'd0, a}, 32'h07);
    @(negedge clk); osc_fail = 1'b1; @(negedge clk); osc_fail = 1'b0;
    rd(1, a); chk("R10 flag set by osc_fail", {24'd0, a}, 32'h87);

    // R2 masks and control readback
    wr(2, 8'hFF); rd(2, a); chk("R2 minute mask", {24'd0, a}, 32'h7F);
    wr(3, 8'hFF); rd(3, a); chk("R2 hour mask", {24'd0, a}, 32'h3F);
    wr(4, 8'hFF); rd(4, a); chk("R2 date mask", {24'd0, a}, 32'h3F);
    wr(5, 8'hFF); rd(5, a); chk("R2 weekday mask", {24'd0, a}, 32'h07);
    wr(6, 8'hFF); rd(6, a); chk("R2 month mask", {24'd0, a}, 32'h1F);
    wr(7, 8'hA5); rd(7, a); chk("R2 year store", {24'd0, a}, 32'hA5);
    wr(0, 8'hE8); rd(0, a); chk("R2 control readback", {24'd0, a}, 32'h28);
    wr(0, 8'h00);

    // R12 soft reset
    set_time(8'h33, 8'h44, 8'h12, 8'h15, 8'h03, 8'h07, 8'h42);
    wr(0, 8'h18);
    for (int i = 0; i < 8; i++) begin
      rd(i, a);
      chk($sformatf("R12 soft reset addr %0d", i), {24'd0, a}, {24'd0, rst_exp[i]});
    end

    // R3 one hour of ticks
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    for (int i = 1; i <= 3600; i++) begin
      tk();
      rd(1, a); rd(2, b); rd(3, c);
      chk($sformatf("R3 tick %0d", i), {8'd0, c, b, a},
          {8'd0, bcd(i / 3600), bcd((i / 60) % 60), bcd(i % 60)});
    end

    // R4 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_time(8'h59, 8'h59, bcd(h), 8'h10, 8'h02, 8'h05, 8'h21);
      tk();
      rd(3, a); rd(4, b); rd(5, c);
      chk($sformatf("R4 hour %0d", h), {8'd0, a, b, c},
          {8'd0, bcd((h + 1) % 24), (h == 23) ? 8'h11 : 8'h10, (h == 23) ? 8'h03 : 8'h02});
    end

    // R5 12-hour sweep
    wr(0, 8'h08);
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        nh = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        set_time(8'h59, 8'h59, 8'((pm << 5) | bcd(h)), 8'h10, 8'h02, 8'h05, 8'h21);
        tk();
        rd(3, a); rd(4, b);
        chk($sformatf("R5 hour %0d pm %0d", h, pm), {16'd0, a, b},
            {16'd0, 8'((npm << 5) | bcd(nh)), (h == 11 && pm == 1) ? 8'h11 : 8'h10});
      end
    end
    wr(0, 8'h00);

    // R8 weekday wrap
    for (int w = 0; w < 7; w++) begin
      set_time(8'h59, 8'h59, 8'h23, 8'h10, 8'(w), 8'h05, 8'h21);
      tk();
      rd(5, a);
      chk($sformatf("R8 weekday %0d", w), {24'd0, a}, {24'd0, 8'((w + 1) % 7)});
    end

    // R6 R7 month ends over all years
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int ld;
        ld = dim(mo, y);
        set_time(8'h59, 8'h59, 8'h23, bcd(ld - 1), 8'h01, bcd(mo), bcd(y));
        tk();
        rd(4, a); rd(6, b); rd(7, c);
        chk($sformatf("R6 day before end %0d/%0d", mo, y), {8'd0, a, b, c},
            {8'd0, bcd(ld), bcd(mo), bcd(y)});
        set_time(8'h59, 8'h59, 8'h23, bcd(ld), 8'h01, bcd(mo), bcd(y));
        tk();
        rd(4, a); rd(6, b); rd(7, c);
        chk($sformatf("R6 R7 month end %0d/%0d", mo, y), {8'd0, a, b, c},
            {8'd0, 8'h01, bcd(mo == 12 ? 1 : mo + 1), bcd(mo == 12 ? (y + 1) % 100 : y)});
      end
    end

    // R9 halt
    set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    wr(0, 8'h20);
    tk(); tk(); tk();
    rd(1, a); chk("R9 halted seconds", {24'd0, a}, 32'h05);
    wr(0, 8'h00);
    tk();
    rd(1, a); chk("R9 resumed seconds", {24'd0, a}, 32'h06);

    // R11 write wins over tick, no carry
    set_time(8'h59, 8'h10, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    wr_tk(2, 8'h30);
    rd(1, a); rd(2, b);
    chk("R11 tick dropped on write", {16'd0, a, b}, {16'd0, 8'h59, 8'h30});
    wr_tk(1, 8'h22);
    rd(1, a); rd(2, b);
    chk("R11 seconds write with tick", {16'd0, a, b}, {16'd0, 8'h22, 8'h30});

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule